// File: doc/BRIEF.md
# Repeating Descriptor-List DMA Engine

This block is a bus-master DMA engine that sits inside the interface of a streaming hardware accelerator. A host processor configures it through a small register port. The host writes a list of transfer descriptors, and each descriptor names a memory start address, a word count and a direction. The direction is either memory into the accelerator's input FIFO, or the accelerator's output FIFO out to memory. The host also sets how many descriptors are active and a repeat count, and then starts the engine.

The engine walks the descriptor list in order and then replays the whole list as many times as the repeat count asks. On every replay, each descriptor resumes at the address where its previous pass stopped, so a contiguous stream in memory is consumed or filled piece by piece. Samples are fetched from memory into the accelerator and results are written back, so each sample crosses the interconnect once in each direction.

On the memory side the engine issues request/grant bursts that are never longer than a fixed maximum. A burst is requested only when the FIFO it touches can absorb or supply all of its words. The host is interrupted once, when the final replay completes, and not after each burst or list.

Top module: `loop_dma`

## Requirements
- R1: Register map, with slot s in 0..NUM_DESC-1:
  - address 4s+0 holds the start address, 4s+1 the word count, and 4s+2 the direction (bit 0: 1 = FIFO to memory, 0 = memory to FIFO).
  - Address NUM_DESC*4+1 holds the active list length, and a value above NUM_DESC is stored as NUM_DESC.
  - Address NUM_DESC*4+2 holds the repeat count.
  - All of these read back what was written while idle.
- R2: While the engine is busy, writes to descriptor, list-length and repeat registers are ignored.
- R3: Writing bit 0 of the control register (address NUM_DESC*4) while idle starts a run. For repetition r from 0 to repeat-1, and for descriptor d from 0 to length-1, the engine moves count_d words at addresses base_d + r*count_d onward, in that order.
- R4: A descriptor's words are split into bursts of MAX_BURST words followed by a shorter remainder. No burst is longer than MAX_BURST or empty.
- R5: A read burst is requested only when inFifoSpace is at least its length. A write burst is requested only when outFifoCount is at least its length. Otherwise the engine waits.
- R6: Each memory read beat pushes memRdata into the input FIFO in the same cycle. Each write beat pops the output FIFO in the same cycle, with outFifoData driven on memWdata.
- R7: memReq, memAddr, memLen and memWrite hold steady until memGnt. The beats follow from the next cycle.
- R8: irq rises exactly once per run, in the cycle the engine leaves busy. It stays high until bit 1 of the control register is written.
- R9: The status register at NUM_DESC*4+3 reports the following fields:
  - bit 0 busy;
  - bit 1 irq;
  - bits 15:8 the current repetition;
  - bits 23:16 the current descriptor index.
- R10: A descriptor with count 0 produces no burst and the list proceeds.
- R11: A start command while busy is ignored.
- R12: Starting with list length 0 or repeat count 0 raises irq without any memory request. After reset the engine is idle, with irq and memReq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Host register write strobe |
| regAddr | input | 5 | Host register address |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data for regAddr |
| irq | output | 1 | Run-complete interrupt |
| memReq | output | 1 | Burst request |
| memWrite | output | 1 | Burst direction, 1 = write to memory |
| memAddr | output | 16 | Burst start word address |
| memLen | output | 3 | Burst length in words |
| memGnt | input | 1 | Burst accepted |
| memRvalid | input | 1 | Read beat valid |
| memRdata | input | 32 | Read beat data |
| memWready | input | 1 | Write beat accepted |
| memWdata | output | 32 | Write beat data |
| inFifoSpace | input | 8 | Free entries in input FIFO |
| inFifoPush | output | 1 | Input FIFO push |
| inFifoData | output | 32 | Input FIFO data |
| outFifoCount | input | 8 | Filled entries in output FIFO |
| outFifoPop | output | 1 | Output FIFO pop |
| outFifoData | input | 32 | Output FIFO head data |

## Verification
The hardest state to reach from the ports is an engine that is stopped partway through a list, later than its first descriptor, with a burst pending and no progress. Only in that state can the status fields, the freeze on configuration writes and the ignored restart be observed.

The stimulus gets there as follows. It holds the input FIFO space at three words. A three-word descriptor then completes, and the next descriptor's four-word burst waits. While the engine waits, the bench reads status, rewrites configuration and re-issues start. It then opens the FIFO space and compares the complete burst log against the arithmetic schedule.

// File: rtl/loop_dma_pkg.sv
package loop_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_WAIT, S_REQ, S_DATA, S_NEXT
  } dmaState_e;

  typedef struct packed {
    logic startRun;
    logic loadDesc;
    logic latchBurst;
    logic beat;
    logic saveDesc;
    logic nextDesc;
    logic nextRep;
    logic finish;
  } dmaStrobe_t;
endpackage

// File: rtl/loop_dma_ctrl.sv
module loop_dma_ctrl
  import loop_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       runEmpty,
  input  logic       remZero,
  input  logic       roomOk,
  input  logic       lastBeat,
  input  logic       listEnd,
  input  logic       repEnd,
  input  logic       memGnt,
  input  logic       beatIn,
  output logic       busy,
  output logic       memReq,
  output logic       inData,
  output dmaStrobe_t stb
);
  dmaState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      S_IDLE: if (startReq) begin
        if (runEmpty) stb.finish = 1'b1;
        else begin
          stb.startRun = 1'b1;
          nxt = S_LOAD;
        end
      end
      S_LOAD: begin
        stb.loadDesc = 1'b1;
        nxt = S_WAIT;
      end
      S_WAIT: begin
        if (remZero)     nxt = S_NEXT;
        else if (roomOk) nxt = S_REQ;
      end
      S_REQ: if (memGnt) begin
        stb.latchBurst = 1'b1;
        nxt = S_DATA;
      end
      S_DATA: if (beatIn) begin
        stb.beat = 1'b1;
        if (lastBeat) nxt = S_WAIT;
      end
      S_NEXT: begin
        stb.saveDesc = 1'b1;
        if (!listEnd) begin
          stb.nextDesc = 1'b1;
          nxt = S_LOAD;
        end else if (!repEnd) begin
          stb.nextRep = 1'b1;
          nxt = S_LOAD;
        end else begin
          stb.finish = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign memReq = (state == S_REQ);
  assign inData = (state == S_DATA);

  // R7: an accepted request is followed by the data phase
  p_grant_to_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt |=> inData);
endmodule

// File: rtl/loop_dma_dp.sv
module loop_dma_dp
  import loop_dma_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int REP_W     = 16,
  parameter int MAX_BURST = 4,
  parameter int LVL_W     = 8,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int REG_AW   = $clog2(NUM_DESC * 4 + 4),
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  input  logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memWready,
  output logic [DATA_W-1:0] memWdata,
  input  logic [LVL_W-1:0]  inFifoSpace,
  output logic              inFifoPush,
  output logic [DATA_W-1:0] inFifoData,
  input  logic [LVL_W-1:0]  outFifoCount,
  output logic              outFifoPop,
  input  logic [DATA_W-1:0] outFifoData,
  input  logic              busy,
  input  logic              inData,
  input  dmaStrobe_t        stb,
  output logic              startReq,
  output logic              runEmpty,
  output logic              remZero,
  output logic              roomOk,
  output logic              lastBeat,
  output logic              listEnd,
  output logic              repEnd,
  output logic              beatIn
);
  localparam int CTRL_BASE = NUM_DESC * 4;

  logic [ADDR_W-1:0] descBase [NUM_DESC];
  logic [CNT_W-1:0]  descCnt  [NUM_DESC];
  logic              descDir  [NUM_DESC];
  logic [ADDR_W-1:0] runAddr  [NUM_DESC];
  logic [IDX_W:0]    listLen;
  logic [REP_W-1:0]  repCount;
  logic [IDX_W-1:0]  curDesc;
  logic [REP_W-1:0]  curRep;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remaining;
  logic              curWrite;
  logic [LEN_W-1:0]  beatsLeft;
  logic [LEN_W-1:0]  burstLen;
  logic              irqQ;

  logic              slotHit, ctlHit, cfgWe, irqClr;
  logic [IDX_W-1:0]  slotSel;

  assign slotHit  = regAddr < REG_AW'(CTRL_BASE);
  assign slotSel  = regAddr[IDX_W+1:2];
  assign ctlHit   = regWe && (regAddr == REG_AW'(CTRL_BASE));
  assign cfgWe    = regWe && !busy;
  assign startReq = ctlHit && regWdata[0] && !busy;
  assign irqClr   = ctlHit && regWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        descBase[i] <= '0;
        descCnt[i]  <= '0;
        descDir[i]  <= 1'b0;
        runAddr[i]  <= '0;
      end
      listLen   <= '0;
      repCount  <= '0;
      curDesc   <= '0;
      curRep    <= '0;
      curAddr   <= '0;
      remaining <= '0;
      curWrite  <= 1'b0;
      beatsLeft <= '0;
      irqQ      <= 1'b0;
    end else begin
      if (cfgWe && slotHit) begin
        for (int i = 0; i < NUM_DESC; i++) begin
          if (slotSel == IDX_W'(i)) begin
            case (regAddr[1:0])
              2'd0:    descBase[i] <= regWdata[ADDR_W-1:0];
              2'd1:    descCnt[i]  <= regWdata[CNT_W-1:0];
              2'd2:    descDir[i]  <= regWdata[0];
              default: ;
            endcase
          end
        end
      end
      if (cfgWe && regAddr == REG_AW'(CTRL_BASE + 1))
        listLen <= (regWdata > 32'(NUM_DESC)) ? (IDX_W+1)'(NUM_DESC) : regWdata[IDX_W:0];
      if (cfgWe && regAddr == REG_AW'(CTRL_BASE + 2))
        repCount <= regWdata[REP_W-1:0];

      if (stb.startRun) begin
        for (int i = 0; i < NUM_DESC; i++) runAddr[i] <= descBase[i];
        curDesc <= '0;
        curRep  <= '0;
      end
      if (stb.loadDesc) begin
        curAddr   <= runAddr[curDesc];
        remaining <= descCnt[curDesc];
        curWrite  <= descDir[curDesc];
      end
      if (stb.latchBurst) beatsLeft <= burstLen;
      if (stb.beat) begin
        curAddr   <= curAddr + 1'b1;
        remaining <= remaining - 1'b1;
        beatsLeft <= beatsLeft - 1'b1;
      end
      if (stb.saveDesc) runAddr[curDesc] <= curAddr;
      if (stb.nextDesc) curDesc <= curDesc + 1'b1;
      if (stb.nextRep) begin
        curRep  <= curRep + 1'b1;
        curDesc <= '0;
      end
      if (stb.finish)  irqQ <= 1'b1;
      else if (irqClr) irqQ <= 1'b0;
    end
  end

  assign burstLen = (remaining > CNT_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : remaining[LEN_W-1:0];
  assign roomOk   = curWrite ? (outFifoCount >= LVL_W'(burstLen))
                             : (inFifoSpace  >= LVL_W'(burstLen));
  assign remZero  = (remaining == '0);
  assign lastBeat = (beatsLeft == LEN_W'(1));
  assign listEnd  = ((IDX_W+1)'(curDesc) + 1'b1) == listLen;
  assign repEnd   = (curRep + 1'b1) == repCount;
  assign runEmpty = (listLen == '0) || (repCount == '0);
  assign beatIn   = curWrite ? memWready : memRvalid;

  assign memWrite   = curWrite;
  assign memAddr    = curAddr;
  assign memLen     = burstLen;
  assign inFifoPush = inData && !curWrite && memRvalid;
  assign inFifoData = memRdata;
  assign outFifoPop = inData && curWrite && memWready;
  assign memWdata   = outFifoData;
  assign irq        = irqQ;

  always_comb begin
    regRdata = '0;
    if (slotHit) begin
      case (regAddr[1:0])
        2'd0:    regRdata = 32'(descBase[slotSel]);
        2'd1:    regRdata = 32'(descCnt[slotSel]);
        2'd2:    regRdata = {31'd0, descDir[slotSel]};
        default: regRdata = '0;
      endcase
    end else begin
      case (regAddr - REG_AW'(CTRL_BASE))
        REG_AW'(1): regRdata = 32'(listLen);
        REG_AW'(2): regRdata = 32'(repCount);
        REG_AW'(3): regRdata = {8'd0, 8'(curDesc), 8'(curRep), 6'd0, irqQ, busy};
        default:    regRdata = '0;
      endcase
    end
  end

  // R4: every request is a non-empty burst within the cap
  p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memLen != '0) && (memLen <= LEN_W'(MAX_BURST)));
  // R5: a read request starts only after the FIFO showed room for all of it
  p_read_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && !memWrite |-> $past(inFifoSpace) >= LVL_W'(memLen));
  // R5: a write request starts only after the FIFO held enough words
  p_write_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && memWrite |-> $past(outFifoCount) >= LVL_W'(memLen));
  // R7: request fields hold until granted
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !$past(stb.latchBurst) && !stb.latchBurst |=> memReq && $stable(memAddr) && $stable(memLen) && $stable(memWrite));
  // R8: leaving busy coincides with a raised interrupt
  p_irq_on_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);
  // R2: configuration stays frozen while busy
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(listLen) && $stable(repCount));
  // R6: never push and pop in the same cycle
  p_fifo_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(inFifoPush && outFifoPop));
endmodule

// File: rtl/loop_dma.sv
module loop_dma
  import loop_dma_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int REP_W     = 16,
  parameter int MAX_BURST = 4,
  parameter int LVL_W     = 8,
  localparam int REG_AW   = $clog2(NUM_DESC * 4 + 4),
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memWready,
  output logic [DATA_W-1:0] memWdata,
  input  logic [LVL_W-1:0]  inFifoSpace,
  output logic              inFifoPush,
  output logic [DATA_W-1:0] inFifoData,
  input  logic [LVL_W-1:0]  outFifoCount,
  output logic              outFifoPop,
  input  logic [DATA_W-1:0] outFifoData
);
  dmaStrobe_t stb;
  logic busy, inData, startReq, runEmpty, remZero, roomOk;
  logic lastBeat, listEnd, repEnd, beatIn;

  loop_dma_ctrl u_ctrl (
    .clk, .rstN, .startReq, .runEmpty, .remZero, .roomOk, .lastBeat,
    .listEnd, .repEnd, .memGnt, .beatIn, .busy, .memReq, .inData, .stb
  );

  loop_dma_dp #(
    .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .REP_W(REP_W), .MAX_BURST(MAX_BURST), .LVL_W(LVL_W)
  ) u_dp (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata, .irq, .memReq,
    .memWrite, .memAddr, .memLen, .memRvalid, .memRdata, .memWready,
    .memWdata, .inFifoSpace, .inFifoPush, .inFifoData, .outFifoCount,
    .outFifoPop, .outFifoData, .busy, .inData, .stb, .startReq, .runEmpty,
    .remZero, .roomOk, .lastBeat, .listEnd, .repEnd, .beatIn
  );
endmodule

// File: tb/tb_loop_dma.sv
`timescale 1ns/1ps
module tb_loop_dma;
  localparam int MAXB   = 4;
  localparam int A_CTRL = 16, A_LIST = 17, A_REP = 18, A_STAT = 19;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq, memReq, memWrite, memGnt, memRvalid, memWready;
  logic [15:0] memAddr;
  logic [2:0]  memLen;
  logic [31:0] memRdata, memWdata, inFifoData, outFifoData;
  logic [7:0]  inFifoSpace = 8'd64, outFifoCount = 8'd64;
  logic inFifoPush, outFifoPop;

  always #5 clk = ~clk;

  loop_dma dut (.*);

  int checks = 0, failures = 0;
  logic [31:0] mem [256];
  int bLog [64], lLog [64], wLog [64];
  logic [31:0] inLog [256];
  int nBursts = 0, nIn = 0, wrCount = 0, irqRises = 0, tick = 0;
  int cfgBase [4], cfgCnt [4], cfgDir [4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and FIFO responder
  initial begin
    int bAddr, bLeft;
    logic bWr, prevIrq;
    bLeft = 0; bAddr = 0; bWr = 1'b0; prevIrq = 1'b0;
    memGnt = 0; memRvalid = 0; memWready = 0; memRdata = '0;
    outFifoData = 32'h1000;
    forever begin
      @(negedge clk);
      memGnt = 0; memRvalid = 0; memWready = 0;
      tick++;
      if (rstN) begin
        if (irq && !prevIrq) irqRises++;
        prevIrq = irq;
        if (bLeft > 0) begin
          if (tick % 3 != 2) begin
            if (bWr) begin
              memWready = 1'b1;
              #1;
              chk(outFifoPop === 1'b1 && memWdata === outFifoData, "R6 write beat", memWdata, outFifoData);
              mem[bAddr[7:0]] = memWdata;
              wrCount++;
              outFifoData = 32'h1000 + 32'(wrCount);
            end else begin
              memRdata = mem[bAddr[7:0]];
              memRvalid = 1'b1;
              #1;
              chk(inFifoPush === 1'b1 && inFifoData === memRdata, "R6 read beat", inFifoData, memRdata);
              if (nIn < 256) inLog[nIn] = inFifoData;
              nIn++;
            end
            bAddr++;
            bLeft--;
          end
        end else if (memReq === 1'b1) begin
          memGnt = 1'b1;
          bAddr = int'(memAddr);
          bLeft = int'(memLen);
          bWr = memWrite;
          if (nBursts < 64) begin
            bLog[nBursts] = bAddr; lLog[nBursts] = bLeft; wLog[nBursts] = int'(bWr);
          end
          nBursts++;
        end
      end
    end
  end

  task automatic regWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 5'(a); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 5'(a);
    #1 d = regRdata;
  endtask

  task automatic setDesc(input int s, input int base, input int cnt, input int dir);
    regWrite(4*s, 32'(base)); regWrite(4*s+1, 32'(cnt)); regWrite(4*s+2, 32'(dir));
    cfgBase[s] = base; cfgCnt[s] = cnt; cfgDir[s] = dir;
  endtask

  task automatic waitIrq(input string tag);
    int n = 0;
    while (irq !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(irq === 1'b1, tag, 32'(irq), 1);
  endtask

  // compare logs against the arithmetic schedule of one run
  task automatic checkRun(input int reps, input int len, input int b0, input int i0, input int w0, input string tag);
    int bi = b0, ri = i0, wi = w0;
    for (int r = 0; r < reps; r++) begin
      for (int d = 0; d < len; d++) begin
        int off = 0;
        while (off < cfgCnt[d]) begin
          int bl = (cfgCnt[d] - off > MAXB) ? MAXB : cfgCnt[d] - off;
          int a = cfgBase[d] + r * cfgCnt[d] + off;
          chk(bLog[bi] == a, {tag, " R3 burst addr"}, 32'(bLog[bi]), 32'(a));
          chk(lLog[bi] == bl, {tag, " R4 burst len"}, 32'(lLog[bi]), 32'(bl));
          chk(wLog[bi] == cfgDir[d], {tag, " R3 burst dir"}, 32'(wLog[bi]), 32'(cfgDir[d]));
          bi++;
          for (int k = 0; k < bl; k++) begin
            if (cfgDir[d] == 0) begin
              chk(inLog[ri] === 32'((a + k) * 7 + 3), {tag, " R3 read data"}, inLog[ri], 32'((a + k) * 7 + 3));
              ri++;
            end else begin
              chk(mem[8'(a + k)] === 32'h1000 + 32'(wi), {tag, " R3 write data"}, mem[8'(a + k)], 32'h1000 + 32'(wi));
              wi++;
            end
          end
          off += bl;
        end
      end
    end
    chk(nBursts == bi, {tag, " R4 burst total"}, 32'(nBursts), 32'(bi));
    chk(nIn == ri, {tag, " R3 read total"}, 32'(nIn), 32'(ri));
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int b0, i0, w0, r0;
    for (int a = 0; a < 256; a++) mem[a] = 32'(a * 7 + 3);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(irq === 1'b0 && memReq === 1'b0, "R12 reset outputs", {30'd0, irq, memReq}, 0);
    regRead(A_STAT, rd);
    chk(rd == 0, "R12 reset status", rd, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 readback and clamp
    setDesc(0, 'h10, 6, 0);
    setDesc(1, 'h80, 5, 1);
    regRead(0, rd); chk(rd == 'h10, "R1 base readback", rd, 'h10);
    regRead(1, rd); chk(rd == 6, "R1 count readback", rd, 6);
    regRead(6, rd); chk(rd == 1, "R1 dir readback", rd, 1);
    regWrite(A_LIST, 9);
    regRead(A_LIST, rd); chk(rd == 4, "R1 list length clamp", rd, 4);
    regWrite(A_LIST, 2);
    regWrite(A_REP, 3);
    regRead(A_REP, rd); chk(rd == 3, "R1 repeat readback", rd, 3);

    // run A: mixed read/write list, three replays
    b0 = nBursts; i0 = nIn; w0 = wrCount; r0 = irqRises;
    regWrite(A_CTRL, 1);
    waitIrq("R8 run A irq");
    checkRun(3, 2, b0, i0, w0, "runA");
    repeat (10) @(negedge clk);
    chk(irqRises == r0 + 1, "R8 single irq rise", 32'(irqRises - r0), 1);
    chk(irq === 1'b1, "R8 irq held", 32'(irq), 1);
    regRead(A_STAT, rd); chk(rd[1:0] == 2'b10, "R9 status after run", rd, 2);
    regWrite(A_CTRL, 2);
    chk(irq === 1'b0, "R8 irq cleared", 32'(irq), 0);

    // run B: zero-count slot, stall on FIFO room
    setDesc(0, 'h40, 0, 0);
    setDesc(1, 'h30, 3, 0);
    setDesc(2, 'h50, 8, 0);
    regWrite(A_LIST, 3);
    regWrite(A_REP, 2);
    inFifoSpace = 8'd3;
    b0 = nBursts; i0 = nIn; w0 = wrCount;
    regWrite(A_CTRL, 1);
    repeat (30) @(negedge clk);
    chk(memReq === 1'b0, "R5 held without room", 32'(memReq), 0);
    chk(nBursts == b0 + 1, "R10 zero slot skipped, R5 stall", 32'(nBursts - b0), 1);
    regRead(A_STAT, rd);
    chk(rd == 32'h0002_0001, "R9 status mid-run", rd, 32'h0002_0001);
    regWrite(0, 'h99);
    regRead(0, rd); chk(rd == 'h40, "R2 write while busy", rd, 'h40);
    regWrite(A_REP, 7);
    regRead(A_REP, rd); chk(rd == 2, "R2 repeat frozen", rd, 2);
    regWrite(A_CTRL, 1);
    regRead(A_STAT, rd);
    chk(rd == 32'h0002_0001, "R11 restart ignored", rd, 32'h0002_0001);
    inFifoSpace = 8'd64;
    waitIrq("R8 run B irq");
    checkRun(2, 3, b0, i0, w0, "runB");
    regWrite(A_CTRL, 2);

    // run C: repeat zero
    regWrite(A_REP, 0);
    b0 = nBursts;
    regWrite(A_CTRL, 1);
    chk(irq === 1'b1, "R12 empty run irq", 32'(irq), 1);
    repeat (5) @(negedge clk);
    chk(nBursts == b0 && memReq === 1'b0, "R12 empty run no request", 32'(nBursts - b0), 0);
    regWrite(A_CTRL, 2);

    // run D: restart from programmed bases
    setDesc(0, 'h10, 6, 0);
    setDesc(1, 'h80, 5, 1);
    regWrite(A_LIST, 2);
    regWrite(A_REP, 1);
    b0 = nBursts; i0 = nIn; w0 = wrCount;
    regWrite(A_CTRL, 3);
    waitIrq("R8 run D irq");
    checkRun(1, 2, b0, i0, w0, "runD");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule